// File: doc/BRIEF.md
# Endianness Load/Store Adapter

This block sits between a processor's load/store unit and a 32-bit little-endian memory port. Each byte, halfword or word access passes through it. The adapter changes that access according to the current byte order. There are three modes: plain little-endian, byte-invariant big-endian, and word-invariant big-endian. In byte-invariant big-endian, multi-byte data is reversed. In word-invariant big-endian, whole words are left unchanged and sub-word accesses are moved to another byte inside the word.

A one-bit endianness status decides whether big-endian is active. Software sets it with a set-endian command. Exception entry saves the bit and forces little-endian. Exception return puts the saved value back. When the status is big-endian, a separate mode input picks the byte-invariant or the word-invariant scheme.

The memory port reads combinationally. An access that fits inside one word completes in the cycle it is accepted. An unaligned access in little-endian or byte-invariant mode crosses a word, so it is split into two beats on consecutive word addresses. Its response comes with the second beat. The access size is encoded 0 for byte, 1 for halfword, and 2 or 3 for word. Byte address bits [1:0] select the lane, and lane k is data bits [8k+7:8k].

Top module: `endian_lsu_adapter`

## Requirements
- R1: In little-endian mode, an access reads or writes lanes starting at the address offset. Read data is right-justified and zero-extended. Write strobes cover exactly the addressed lanes. Strobes are zero on reads.
- R2: In byte-invariant big-endian mode, a byte access gives the same result as in little-endian mode.
- R3: In byte-invariant big-endian mode, halfword and word data are byte-reversed relative to little-endian, on both reads and writes.
- R4: In word-invariant big-endian mode, an aligned word access gives the same result as in little-endian mode.
- R5: In word-invariant big-endian mode, a byte access uses offset XOR 3 and a halfword access uses offset XOR 2. The data is not reversed, and the strobes follow the redirected offset.
- R6: In word-invariant big-endian mode, a halfword at an odd offset or a word at a nonzero offset raises rsp_fault in its acceptance cycle. No memory beat is issued and memory is unchanged. Byte accesses never fault.
- R7: In little-endian and byte-invariant modes, an access that crosses a word boundary uses two beats: word N, then word N+1. req_ready is low during the second beat. The assembled response appears with the second beat.
- R8: A set-endian command loads the status bit, and the new value is visible on endian_big from the next cycle.
- R9: Exception entry saves the status bit and clears it, and it overrides a set-endian command in the same cycle. Exception return restores the saved bit. After exception entry, accesses behave as little-endian.
- R10: The endianness and the mode select are captured when a split access is accepted. Changes to either during its second beat do not affect the result.
- R11: After reset, endian_big is 0, req_ready is 1 and no memory beat is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Low while a second beat is in progress |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mode_word_inv | input | 1 | Big-endian scheme: 1 word-invariant, 0 byte-invariant |
| setend_valid | input | 1 | Set-endian command |
| setend_big | input | 1 | Value written by set-endian |
| exc_enter | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| endian_big | output | 1 | Current status bit |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_fault | output | 1 | Alignment fault |
| rsp_rdata | output | 32 | Load data, right-justified |
| mem_en | output | 1 | Memory beat this cycle |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW-2 | Word address of the beat |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Combinational read data |

## Verification
Several rules are checked by assertions on every cycle:
- A fault never comes with a memory beat.
- A split always produces a second beat to the next word, with ready low.
- A write beat always has at least one strobe.
- Set-endian, exception entry and exception return always move the status bit as defined.

The data itself can only be shown by the bench's scenarios, because it depends on memory contents. This covers the reversal in byte-invariant mode, the redirected lanes in word-invariant mode, the assembly of split reads and writes, and the fact that the mode is held across a split.

// File: rtl/endian_adapter_pkg.sv
package endian_adapter_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00ff;
      SZ_HALF: return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [3:0] strb_base(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'b0001;
      SZ_HALF: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // reverse the bytes that belong to an access of the given size
  function automatic logic [31:0] reverse_bytes(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return d;
      SZ_HALF: return {16'd0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  // offset flip used by the word-invariant scheme
  function automatic logic [1:0] wi_flip(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 2'b11;
      SZ_HALF: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic crosses_word(input logic [1:0] off, input logic [1:0] sz);
    return ({1'b0, off} + size_bytes(sz)) > 3'd4;
  endfunction

  function automatic logic natural_misalign(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      default: return off != 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/endian_status_reg.sv
module endian_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic setend_valid,
  input  logic setend_big,
  input  logic exc_enter,
  input  logic exc_return,
  output logic big_now,
  output logic big_saved
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      big_now   <= 1'b0;
      big_saved <= 1'b0;
    end else if (exc_enter) begin
      big_saved <= big_now;
      big_now   <= 1'b0;
    end else if (exc_return) begin
      big_now <= big_saved;
    end else if (setend_valid) begin
      big_now <= setend_big;
    end
  end
endmodule

// File: rtl/endian_access_planner.sv
module endian_access_planner
  import endian_adapter_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          big,
  input  logic          word_inv,
  output logic [1:0]    eff_off,
  output logic [AW-3:0] word_addr,
  output logic          swap,
  output logic          fault,
  output logic          split
);
  logic wi_active;

  always_comb begin
    wi_active = big & word_inv;
    eff_off   = wi_active ? (addr[1:0] ^ wi_flip(size)) : addr[1:0];
    word_addr = addr[AW-1:2];
    swap      = big & ~word_inv;
    fault     = wi_active & natural_misalign(addr[1:0], size);
    split     = ~wi_active & crosses_word(addr[1:0], size);
  end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import endian_adapter_pkg::*;
(
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  input  logic        swap,
  input  logic [31:0] wdata,
  input  logic [31:0] lo_rdata,
  input  logic [31:0] hi_rdata,
  output logic [63:0] lane_wdata,
  output logic [7:0]  lane_strb,
  output logic [31:0] rdata
);
  logic [31:0] wsrc;
  logic [63:0] joined;
  logic [31:0] raw;

  always_comb begin
    wsrc       = (swap ? reverse_bytes(wdata, size) : wdata) & size_mask(size);
    lane_wdata = {32'd0, wsrc} << {off, 3'b000};
    lane_strb  = {4'b0000, strb_base(size)} << off;
    joined     = {hi_rdata, lo_rdata} >> {off, 3'b000};
    raw        = joined[31:0] & size_mask(size);
    rdata      = swap ? reverse_bytes(raw, size) : raw;
  end
endmodule

// File: rtl/endian_lsu_adapter.sv
module endian_lsu_adapter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic          mode_word_inv,
  input  logic          setend_valid,
  input  logic          setend_big,
  input  logic          exc_enter,
  input  logic          exc_return,
  output logic          endian_big,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [31:0]   rsp_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_wstrb,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int WAW = AW - 2;

  logic            big_saved;
  logic [1:0]      plan_off;
  logic [WAW-1:0]  plan_waddr;
  logic            plan_swap, plan_fault, plan_split;
  logic            accept, split_start, beat2_active;
  logic [1:0]      q_off, q_size;
  logic            q_swap, q_write;
  logic [WAW-1:0]  q_next_addr;
  logic [3:0]      q_hi_strb;
  logic [31:0]     q_hi_wdata, q_lo_rdata;
  logic [1:0]      st_off, st_size;
  logic            st_swap, cur_write;
  logic [31:0]     st_lo, st_hi, steer_rdata;
  logic [63:0]     lane_wdata;
  logic [7:0]      lane_strb;

  endian_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .setend_valid(setend_valid), .setend_big(setend_big),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .big_now(endian_big), .big_saved(big_saved)
  );

  endian_access_planner #(.AW(AW)) u_plan (
    .addr(req_addr), .size(req_size), .big(endian_big), .word_inv(mode_word_inv),
    .eff_off(plan_off), .word_addr(plan_waddr), .swap(plan_swap),
    .fault(plan_fault), .split(plan_split)
  );

  assign req_ready   = ~beat2_active;
  assign accept      = req_valid & req_ready;
  assign split_start = accept & plan_split;
  assign cur_write   = beat2_active ? q_write : req_write;

  // steering runs on the captured plan during the second beat
  assign st_off  = beat2_active ? q_off  : plan_off;
  assign st_size = beat2_active ? q_size : req_size;
  assign st_swap = beat2_active ? q_swap : plan_swap;
  assign st_lo   = beat2_active ? q_lo_rdata : mem_rdata;
  assign st_hi   = beat2_active ? mem_rdata  : 32'd0;

  endian_lane_steer u_steer (
    .off(st_off), .size(st_size), .swap(st_swap), .wdata(req_wdata),
    .lo_rdata(st_lo), .hi_rdata(st_hi),
    .lane_wdata(lane_wdata), .lane_strb(lane_strb), .rdata(steer_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat2_active <= 1'b0;
      q_off        <= 2'd0;
      q_size       <= 2'd0;
      q_swap       <= 1'b0;
      q_write      <= 1'b0;
      q_next_addr  <= '0;
      q_hi_strb    <= 4'd0;
      q_hi_wdata   <= 32'd0;
      q_lo_rdata   <= 32'd0;
    end else if (split_start) begin
      beat2_active <= 1'b1;
      q_off        <= plan_off;
      q_size       <= req_size;
      q_swap       <= plan_swap;
      q_write      <= req_write;
      q_next_addr  <= plan_waddr + 1'b1;
      q_hi_strb    <= lane_strb[7:4];
      q_hi_wdata   <= lane_wdata[63:32];
      q_lo_rdata   <= mem_rdata;
    end else begin
      beat2_active <= 1'b0;
    end
  end

  assign mem_en    = beat2_active | (accept & ~plan_fault);
  assign mem_we    = cur_write;
  assign mem_addr  = beat2_active ? q_next_addr : plan_waddr;
  assign mem_wstrb = !cur_write ? 4'd0 : (beat2_active ? q_hi_strb : lane_strb[3:0]);
  assign mem_wdata = beat2_active ? q_hi_wdata : lane_wdata[31:0];
  assign rsp_valid = beat2_active | (accept & ~plan_split);
  assign rsp_fault = accept & plan_fault;
  assign rsp_rdata = (rsp_valid & ~rsp_fault & ~cur_write) ? steer_rdata : 32'd0;
endmodule

// File: rtl/endian_adapter_checks.sv
module endian_adapter_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_en,
  input logic          mem_we,
  input logic [3:0]    mem_wstrb,
  input logic [AW-3:0] mem_addr,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic          endian_big,
  input logic          big_saved,
  input logic          setend_valid,
  input logic          setend_big,
  input logic          exc_enter,
  input logic          exc_return,
  input logic          split_start,
  input logic          beat2_active
);
  AST_FAULT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (!mem_en && rsp_valid)); // R6
  AST_WRITE_HAS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_wstrb != 4'd0)); // R5
  AST_SPLIT_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> (beat2_active && mem_en && rsp_valid && !req_ready)); // R7
  AST_SPLIT_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> (mem_addr == $past(mem_addr) + 1'b1)); // R7
  AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (!endian_big && big_saved == $past(endian_big))); // R9
  AST_EXC_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> (endian_big == $past(big_saved))); // R9
  AST_SETEND_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (setend_valid && !exc_enter && !exc_return) |=> (endian_big == $past(setend_big))); // R8
endmodule

bind endian_lsu_adapter endian_adapter_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_en(mem_en), .mem_we(mem_we),
  .mem_wstrb(mem_wstrb), .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .endian_big(endian_big), .big_saved(big_saved), .setend_valid(setend_valid),
  .setend_big(setend_big), .exc_enter(exc_enter), .exc_return(exc_return),
  .split_start(split_start), .beat2_active(beat2_active)
);

// File: tb/endian_lsu_adapter_test.sv
`timescale 1ns/1ps
module endian_lsu_adapter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, mode_word_inv = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic setend_valid = 0, setend_big = 0, exc_enter = 0, exc_return = 0;
  logic req_ready, endian_big, rsp_valid, rsp_fault, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [29:0] mem_addr;
  logic [3:0] mem_wstrb;
  logic [31:0] mem [16];
  int n_checks = 0, n_errors = 0;

  always #2 clk = ~clk;

  endian_lsu_adapter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mode_word_inv(mode_word_inv), .setend_valid(setend_valid), .setend_big(setend_big),
    .exc_enter(exc_enter), .exc_return(exc_return), .endian_big(endian_big),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[3:0]];
  always @(posedge clk)
    if (mem_en && mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_wstrb[k]) mem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output logic flt,
                        output int beats, output logic [3:0] strb0);
    beats = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    #1;
    if (mem_en) beats++;
    strb0 = mem_wstrb; rd = rsp_rdata; flt = rsp_fault;
    if (!rsp_valid) begin
      @(negedge clk);
      req_valid = 0;
      #1;
      if (mem_en) beats++;
      rd = rsp_rdata; flt = rsp_fault;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic setend(input logic b);
    @(negedge clk); setend_valid = 1; setend_big = b;
    @(negedge clk); setend_valid = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R11 endian_big", {31'd0, endian_big}, 32'd0);
    check("R11 req_ready", {31'd0, req_ready}, 32'd1);
    check("R11 mem_en", {31'd0, mem_en}, 32'd0);
  endtask

  task automatic t_little();
    logic [31:0] rd; logic f; int b; logic [3:0] s;
    mem[1] = 32'h4433_2211;
    access(0, 2'd0, 32'h6, 0, rd, f, b, s); check("R1 byte read", rd, 32'h33);
    access(0, 2'd1, 32'h6, 0, rd, f, b, s); check("R1 half read", rd, 32'h4433);
    access(0, 2'd2, 32'h4, 0, rd, f, b, s); check("R1 word read", rd, 32'h4433_2211);
    check("R1 read strobes", {28'd0, s}, 32'd0);
    access(1, 2'd0, 32'h5, 32'hAA, rd, f, b, s);
    check("R1 byte write strobe", {28'd0, s}, 32'b0010);
    check("R1 byte write mem", mem[1], 32'h4433_AA11);
  endtask

  task automatic t_byte_inv();
    logic [31:0] rd; logic f; int b; logic [3:0] s;
    mode_word_inv = 0;
    setend(1);
    check("R8 setend big", {31'd0, endian_big}, 32'd1);
    mem[1] = 32'h4433_2211;
    access(0, 2'd0, 32'h6, 0, rd, f, b, s); check("R2 byte read", rd, 32'h33);
    access(0, 2'd1, 32'h4, 0, rd, f, b, s); check("R3 half read", rd, 32'h1122);
    access(0, 2'd2, 32'h4, 0, rd, f, b, s); check("R3 word read", rd, 32'h1122_3344);
    mem[2] = 0;
    access(1, 2'd2, 32'h8, 32'hA1B2_C3D4, rd, f, b, s);
    check("R3 word write", mem[2], 32'hD4C3_B2A1);
    mem[2] = 32'h4433_2211; mem[3] = 32'h8877_6655;
    access(0, 2'd2, 32'hA, 0, rd, f, b, s);
    check("R7 split read data", rd, 32'h3344_5566);
    check("R7 split beats", b, 2);
    access(1, 2'd1, 32'hB, 32'hBEEF, rd, f, b, s);
    check("R7 split write lo", mem[2], 32'hBE33_2211);
    check("R7 split write hi", mem[3], 32'h8877_66EF);
  endtask

  task automatic t_mode_hold();
    mem[2] = 32'h4433_2211; mem[3] = 32'h8877_6655;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2'd2; req_addr = 32'hA;
    setend_valid = 1; setend_big = 0;
    #1;
    check("R7 no rsp first beat", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    req_valid = 0; setend_valid = 0; mode_word_inv = 1;
    #1;
    check("R7 ready low beat2", {31'd0, req_ready}, 32'd0);
    check("R10 held mode data", rsp_rdata, 32'h3344_5566);
    check("R10 status changed", {31'd0, endian_big}, 32'd0);
    @(negedge clk);
    mode_word_inv = 0;
  endtask

  task automatic t_le_split();
    logic [31:0] rd; logic f; int b; logic [3:0] s;
    access(0, 2'd2, 32'hA, 0, rd, f, b, s);
    check("R7 little split read", rd, 32'h6655_4433);
  endtask

  task automatic t_word_inv();
    logic [31:0] rd; logic f; int b; logic [3:0] s;
    mode_word_inv = 1;
    setend(1);
    mem[1] = 32'h4433_2211;
    access(0, 2'd2, 32'h4, 0, rd, f, b, s); check("R4 word read", rd, 32'h4433_2211);
    access(0, 2'd0, 32'h4, 0, rd, f, b, s); check("R5 byte 0 read", rd, 32'h44);
    access(0, 2'd0, 32'h7, 0, rd, f, b, s); check("R5 byte 3 read", rd, 32'h11);
    access(0, 2'd1, 32'h4, 0, rd, f, b, s); check("R5 half read", rd, 32'h4433);
    access(1, 2'd0, 32'h4, 32'h5A, rd, f, b, s);
    check("R5 byte strobe", {28'd0, s}, 32'b1000);
    check("R5 byte write mem", mem[1], 32'h5A33_2211);
    access(1, 2'd2, 32'h6, 32'hDEAD_BEEF, rd, f, b, s);
    check("R6 word fault", {31'd0, f}, 32'd1);
    check("R6 no beat", b, 0);
    check("R6 mem kept", mem[1], 32'h5A33_2211);
    access(1, 2'd1, 32'h5, 32'hFFFF, rd, f, b, s);
    check("R6 half fault", {31'd0, f}, 32'd1);
    check("R6 mem kept half", mem[1], 32'h5A33_2211);
    access(0, 2'd0, 32'h5, 0, rd, f, b, s);
    check("R6 byte no fault", {31'd0, f}, 32'd0);
  endtask

  task automatic t_exception();
    logic [31:0] rd; logic f; int b; logic [3:0] s;
    mode_word_inv = 0;
    @(negedge clk); exc_enter = 1; setend_valid = 1; setend_big = 1;
    @(negedge clk); exc_enter = 0; setend_valid = 0;
    check("R9 entry clears", {31'd0, endian_big}, 32'd0);
    mem[1] = 32'h4433_2211;
    access(0, 2'd2, 32'h4, 0, rd, f, b, s);
    check("R9 little after entry", rd, 32'h4433_2211);
    @(negedge clk); exc_return = 1;
    @(negedge clk); exc_return = 0;
    check("R9 return restores", {31'd0, endian_big}, 32'd1);
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_little();
    t_byte_inv();
    t_mode_hold();
    t_le_split();
    t_word_inv();
    t_exception();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule